// File: doc/BRIEF.md
# Strided Vector Operand Fetch Sequencer

The sequencer walks one vector operand through a banked memory. Software-side control hands it a base byte address, an element count, an element stride and a lane-count cap. The sequencer then issues one group of element addresses per accepted cycle, and each group has a lane-valid mask. The group size is the effective lane width. It is the smaller of two numbers: the cap, and a limit set by the stride taken modulo 8. Some stride classes hit the same bank pairs repeatedly, and these are held to fewer lanes.

A consumer drives `ready` to take each group. While `ready` is low, the current group is held unchanged. After the last group is accepted, the sequencer raises `done` for exactly one cycle and returns to idle. A start request is acted on only when the sequencer is idle.

Top module: `svfs_fetch_seq`

## Requirements
- R1: After reset, `issueValid`, `done` and `laneMask` are all 0. `laneMask` stays 0 in every cycle where `issueValid` is 0.
- R2: A stride of 0 or 1, or a stride whose value mod 8 is 2, 3, 5 or 6, allows the full capped width.
- R3: A stride other than 1 whose value mod 8 is 1 or 7, and any stride whose value mod 8 is 4, is limited to 2 lanes per group.
- R4: A stride other than 0 whose value mod 8 is 0 is limited to 1 lane per group.
- R5: `widthLog2` gives the cap as 2^widthLog2 lanes (0→1, 1→2, 2→4, 3→8, never above MAX_LANES). The effective width is the smaller of the cap and the stride limit.
- R6: Lane l of group g carries element index i = g·W + l, where W is the effective width. Its address is base + i·stride·ELEM_BYTES, modulo 2^ADDR_W.
- R7: `laneMask` bit l is 1 exactly for the lanes that hold an element still to be fetched. Every group except the final one sets the low W bits, and the final group sets only the remaining elements.
- R8: While `issueValid` is 1 and `ready` is 0, the next cycle shows the same group, with the same mask and addresses. No element is skipped.
- R9: `done` is 1 for exactly one cycle: the cycle after the last group is accepted. `issueValid` is 0 in that cycle.
- R10: A start with length 0 issues no group, and `done` is 1 in the cycle after the start.
- R11: A `start` arriving while a vector is running, or during the `done` cycle, is ignored. The running vector continues unchanged, and no new vector begins.
- R12: The first group is presented with `issueValid` = 1 in the cycle after the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a vector (taken only when idle) |
| baseAddr | input | ADDR_W | Byte address of element 0 |
| vecLen | input | LEN_W | Element count |
| stride | input | STRIDE_W | Element stride, in elements |
| widthLog2 | input | WSEL_W | Log2 of the lane-count cap |
| ready | input | 1 | Consumer accepts the presented group |
| laneAddr | output | MAX_LANES*ADDR_W | Lane l address in bits [l*ADDR_W +: ADDR_W] |
| laneMask | output | MAX_LANES | Lane-valid mask |
| issueValid | output | 1 | A group is presented |
| done | output | 1 | One-cycle end-of-vector pulse |

## Verification
The bench uses the default parameters: eight lanes, 32-bit addresses, 2-byte elements and 12-bit length and stride. With these values, all four cap settings can be exercised, and both limited stride classes fall strictly below the full width. Strides up to 4095 and lengths up to 40 produce multi-group vectors with partial final groups under each width. Random stalls on `ready` make the group-holding behaviour visible.

// File: rtl/svfs_pkg.sv
package svfs_pkg;

  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobe_t;

  // Lane limit imposed by the stride class; full means maxLanes.
  function automatic int unsigned strideLimit(input logic [31:0] strideVal,
                                              input int unsigned maxLanes);
    int unsigned lim;
    case (strideVal[2:0])
      3'd0:       lim = (strideVal == 32'd0) ? maxLanes : 1;
      3'd1, 3'd7: lim = (strideVal == 32'd1) ? maxLanes : 2;
      3'd4:       lim = 2;
      default:    lim = maxLanes;
    endcase
    return (lim > maxLanes) ? maxLanes : lim;
  endfunction

endpackage

// File: rtl/svfs_ctrl.sv
module svfs_ctrl
  import svfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       lenZero,
  input  logic       lastGroup,
  input  logic       ready,
  output seqStrobe_t strobe,
  output logic       issueValid,
  output logic       done
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seqState_t;

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = lenZero ? ST_FIN : ST_RUN;
      ST_RUN:  if (ready && lastGroup) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strobe.load    = (state == ST_IDLE) && start;
    strobe.advance = (state == ST_RUN) && ready;
  end

  assign issueValid = (state == ST_RUN);
  assign done       = (state == ST_FIN);

endmodule

// File: rtl/svfs_datapath.sv
module svfs_datapath
  import svfs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int STRIDE_W   = 12,
  parameter int WSEL_W     = 2,
  parameter int MAX_LANES  = 8,
  parameter int ELEM_BYTES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  seqStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]             baseAddr,
  input  logic [LEN_W-1:0]              vecLen,
  input  logic [STRIDE_W-1:0]           stride,
  input  logic [WSEL_W-1:0]             widthLog2,
  output logic                          lenZero,
  output logic                          lastGroup,
  output logic [MAX_LANES*ADDR_W-1:0]   laneAddr,
  output logic [MAX_LANES-1:0]          laneMask
);

  localparam int CNT_W = $clog2(MAX_LANES + 1);

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] strideBytes;
  logic [LEN_W-1:0]  remaining;
  logic [CNT_W-1:0]  effW;
  logic [CNT_W-1:0]  effWNext;

  always_comb begin
    int unsigned lim;
    int unsigned cap;
    lim = strideLimit(32'(stride), MAX_LANES);
    cap = 32'd1 << widthLog2;
    if (cap > MAX_LANES) cap = MAX_LANES;
    effWNext = CNT_W'((lim < cap) ? lim : cap);
  end

  assign lenZero   = (vecLen == '0);
  assign lastGroup = (remaining <= LEN_W'(effW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr     <= '0;
      strideBytes <= '0;
      remaining   <= '0;
      effW        <= '0;
    end else if (strobe.load) begin
      curAddr     <= baseAddr;
      strideBytes <= ADDR_W'(stride) * ADDR_W'(ELEM_BYTES);
      remaining   <= vecLen;
      effW        <= effWNext;
    end else if (strobe.advance) begin
      curAddr   <= curAddr + ADDR_W'(effW) * strideBytes;
      remaining <= lastGroup ? '0 : remaining - LEN_W'(effW);
    end
  end

  for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
    assign laneAddr[l*ADDR_W +: ADDR_W] = curAddr + ADDR_W'(l) * strideBytes;
    assign laneMask[l] = (CNT_W'(l) < effW) && (LEN_W'(l) < remaining);
  end

endmodule

// File: rtl/svfs_fetch_seq.sv
module svfs_fetch_seq
  import svfs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int STRIDE_W   = 12,
  parameter int WSEL_W     = 2,
  parameter int MAX_LANES  = 8,
  parameter int ELEM_BYTES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [ADDR_W-1:0]           baseAddr,
  input  logic [LEN_W-1:0]            vecLen,
  input  logic [STRIDE_W-1:0]         stride,
  input  logic [WSEL_W-1:0]           widthLog2,
  input  logic                        ready,
  output logic [MAX_LANES*ADDR_W-1:0] laneAddr,
  output logic [MAX_LANES-1:0]        laneMask,
  output logic                        issueValid,
  output logic                        done
);

  seqStrobe_t           strobe;
  logic                 lenZero;
  logic                 lastGroup;
  logic [MAX_LANES-1:0] rawMask;

  svfs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .lenZero    (lenZero),
    .lastGroup  (lastGroup),
    .ready      (ready),
    .strobe     (strobe),
    .issueValid (issueValid),
    .done       (done)
  );

  svfs_datapath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .STRIDE_W   (STRIDE_W),
    .WSEL_W     (WSEL_W),
    .MAX_LANES  (MAX_LANES),
    .ELEM_BYTES (ELEM_BYTES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .baseAddr  (baseAddr),
    .vecLen    (vecLen),
    .stride    (stride),
    .widthLog2 (widthLog2),
    .lenZero   (lenZero),
    .lastGroup (lastGroup),
    .laneAddr  (laneAddr),
    .laneMask  (rawMask)
  );

  assign laneMask = rawMask & {MAX_LANES{issueValid}};

endmodule

// File: rtl/svfs_fetch_seq_chk.sv
module svfs_fetch_seq_chk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_LANES = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ready,
  input logic                        issueValid,
  input logic                        done,
  input logic [MAX_LANES-1:0]        laneMask,
  input logic [MAX_LANES*ADDR_W-1:0] laneAddr
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && issueValid));  // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && !ready) |=> (issueValid && $stable(laneMask) && $stable(laneAddr)));  // R8

  AST_MASK_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |-> ((laneMask != '0) && ((laneMask & (laneMask + 1'b1)) == '0)));  // R7

  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !issueValid |-> (laneMask == '0));  // R1

endmodule

bind svfs_fetch_seq svfs_fetch_seq_chk #(
  .ADDR_W    (ADDR_W),
  .MAX_LANES (MAX_LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .issueValid (issueValid),
  .done       (done),
  .laneMask   (laneMask),
  .laneAddr   (laneAddr)
);

// File: tb/svfs_fetch_seq_tb_top.sv
module svfs_fetch_seq_tb_top;

  localparam int ADDR_W = 32;
  localparam int LEN_W = 12;
  localparam int STRIDE_W = 12;
  localparam int WSEL_W = 2;
  localparam int LANES = 8;
  localparam int EBYTES = 2;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    start = 1'b0;
  logic [ADDR_W-1:0]       baseAddr = '0;
  logic [LEN_W-1:0]        vecLen = '0;
  logic [STRIDE_W-1:0]     stride = '0;
  logic [WSEL_W-1:0]       widthLog2 = '0;
  logic                    ready = 1'b0;
  logic [LANES*ADDR_W-1:0] laneAddr;
  logic [LANES-1:0]        laneMask;
  logic                    issueValid;
  logic                    done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  svfs_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .baseAddr(baseAddr),
    .vecLen(vecLen), .stride(stride), .widthLog2(widthLog2), .ready(ready),
    .laneAddr(laneAddr), .laneMask(laneMask), .issueValid(issueValid), .done(done)
  );

  function automatic int expLimit(input int s);
    case (s % 8)
      0: return (s == 0) ? LANES : 1;
      1, 7: return (s == 1) ? LANES : 2;
      4: return 2;
      default: return LANES;
    endcase
  endfunction

  function automatic int expEff(input int s, input int wl);
    int cap = 1 << wl;
    int lim = expLimit(s);
    if (cap > LANES) cap = LANES;
    return (lim < cap) ? lim : cap;
  endfunction

  function automatic string classTag(input int s);
    int lim = expLimit(s);
    if (lim == LANES) return "R2";
    if (lim == 2) return "R3";
    return "R4";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runVec(input logic [31:0] b, input int len, input int s,
                        input int wl, input int stallPct, input bit poke);
    int eff = expEff(s, wl);
    int idx = 0;
    int guard = 0;
    @(negedge clk);
    start = 1'b1; baseAddr = b; vecLen = LEN_W'(len);
    stride = STRIDE_W'(s); widthLog2 = WSEL_W'(wl); ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (len == 0) begin
      check(done && !issueValid, "R10", "empty vector done", {62'd0, done, issueValid}, 64'd2);
    end else begin
      check(issueValid == 1'b1, "R12", "first group valid", 64'(issueValid), 64'd1);
      while (idx < len && guard < 2000) begin
        int n = (len - idx < eff) ? (len - idx) : eff;
        logic [LANES-1:0] em = LANES'((1 << n) - 1);
        bit aok = 1'b1;
        logic [31:0] aAct = '0;
        logic [31:0] aExp = '0;
        guard++;
        check(issueValid && laneMask == em, (n < eff) ? "R7" : classTag(s),
              "lane mask", 64'(laneMask), 64'(em));
        for (int l = 0; l < LANES; l++) begin
          logic [31:0] ea = b + 32'((idx + l) * s * EBYTES);
          if (em[l] && laneAddr[l*ADDR_W +: ADDR_W] != ea && aok) begin
            aok = 1'b0; aAct = laneAddr[l*ADDR_W +: ADDR_W]; aExp = ea;
          end
        end
        check(aok, "R6", "lane address", 64'(aAct), 64'(aExp));
        ready = (($urandom % 100) >= 32'(stallPct));
        if (poke) begin
          start = (($urandom % 4) == 0);  // R11: ignored while running
          baseAddr = $urandom;
          vecLen = LEN_W'($urandom);
        end
        @(negedge clk);
        if (ready) idx += eff;  // R8: a stalled group must reappear unchanged
      end
      start = 1'b0; ready = 1'b0;
      check(done && !issueValid, "R9", "done after last group", {62'd0, done, issueValid}, 64'd2);
    end
    start = poke;  // R11: start during the done cycle is ignored
    baseAddr = $urandom;
    vecLen = 12'd5;
    @(negedge clk);
    start = 1'b0;
    check(!done && !issueValid, poke ? "R11" : "R9", "idle after done",
          {62'd0, done, issueValid}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk);
    check(!issueValid && !done && laneMask == '0, "R1", "reset outputs",
          {54'd0, laneMask, issueValid, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!issueValid && laneMask == '0, "R1", "idle after reset",
          {55'd0, laneMask, issueValid}, 64'd0);

    runVec(32'h1000, 20, 1, 3, 0, 0);    // R2 unit stride, full width
    runVec(32'h2000, 5, 0, 3, 0, 0);     // R2 zero stride
    runVec(32'h3000, 17, 3, 3, 20, 0);   // R2
    runVec(32'h3100, 11, 6, 3, 0, 0);    // R2
    runVec(32'h4000, 9, 9, 3, 0, 0);     // R3 mod 1
    runVec(32'h4100, 7, 7, 3, 30, 0);    // R3 mod 7
    runVec(32'h4200, 6, 4, 3, 0, 0);     // R3 mod 4
    runVec(32'h4300, 5, 12, 3, 0, 0);    // R3
    runVec(32'h5000, 4, 8, 3, 0, 0);     // R4
    runVec(32'h5100, 3, 16, 3, 50, 0);   // R4 with stalls
    runVec(32'h6000, 10, 3, 0, 0, 0);    // R5 cap 1
    runVec(32'h6100, 10, 5, 1, 0, 0);    // R5 cap 2
    runVec(32'h6200, 10, 2, 2, 0, 0);    // R5 cap 4
    runVec(32'h6300, 5, 4, 0, 0, 0);     // R5 cap below stride limit
    runVec(32'h7000, 0, 3, 3, 0, 0);     // R10
    runVec(32'hFFFF_FFF0, 12, 3, 3, 0, 0);  // R6 address wrap
    runVec(32'h8000, 25, 2, 3, 60, 1);   // R8 stalls, R11 pokes

    for (int k = 0; k < 40; k++) begin
      runVec($urandom, int'($urandom % 41), int'($urandom % 4096),
             int'($urandom % 4), int'($urandom % 50), bit'($urandom % 2));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule